// File: doc/BRIEF.md
# Five-Channel Timer Register Bank with Interrupt Status

This block is the 32-bit memory-mapped front end of a group of countdown timer channels. A simple request interface carries a valid strobe, a write flag, a byte address and write data. The block decodes word-aligned addresses to three registers per channel: control, reload value and live count. It also decodes a shared interrupt-status register and a watchdog-control register. Writes go to the addressed channel. Read data comes back from a register one cycle after the request.

Each channel is a small down-counter with a prescaler, a one-shot or auto-reload mode, and an interrupt-enable bit. When a channel counts down to zero it produces a one-cycle zero event. The bank latches that event into that channel's bit of the status register. Software clears status bits by writing ones to them. One interrupt line per channel is raised while that channel's status bit and its enable bit are both set. The watchdog-control register only returns its reset constant.

Top module: `tmr_bank`

## Requirements
- R1: Channel c has its control word at byte offset (c/2)*0x20 + (c%2)*4, its reload word 8 bytes higher, and its live-count word 16 bytes higher. For five channels this gives control at 0x00, 0x04, 0x20, 0x24 and 0x40, reload at 0x08, 0x0C, 0x28, 0x2C and 0x48, and live count at 0x10, 0x14, 0x30, 0x34 and 0x50. The status word is at 0x18 and the watchdog-control word is at 0x1C.
- R2: A read request is answered on rdata_o in the cycle after the request. rdata_o keeps that value until the next read request.
- R3: When channel c reaches zero, bit c of the status word is set on the same clock edge.
- R4: A write to the status word clears every bit written as one and leaves every bit written as zero unchanged. If a zero event and a clearing write hit the same bit on the same edge, the bit ends up set.
- R5: irq_o[c] is high exactly while status bit c is 1 and control bit 1 (interrupt enable) of channel c is 1. It follows either of them on the next edge.
- R6: Live-count words are read-only. A write to one of them changes no register.
- R7: A read of an unmapped offset, or of any address whose low two bits are not zero, returns 0. A write to such an address changes no register.
- R8: After reset the status word is 0, the watchdog-control word reads 0x00000400, every control, reload and live-count word reads 0, and every irq_o is low. Writes to the watchdog-control word have no effect.
- R9: Control bit 0 is run, bit 1 is interrupt enable, bit 2 is auto-reload, and bits 15:8 are the prescale value P. All other bits read as 0. Writing the reload word also loads the live count and restarts the prescaler. While run is 1 and the count is nonzero, the count drops by one every P+1 cycles. A cycle that writes the channel's control or reload word does no count step. A step from 1 to 0 is a zero event. In auto-reload mode that step reloads the count instead, and run stays 1. In one-shot mode the count stays 0 and run clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (12) | Byte address of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | NUM_CH (5) | Per-channel interrupt lines |

## Verification
The hardest case to reach from the ports is a status-clearing write that lands on exactly the edge where the same channel's count steps from 1 to 0. The stimulus sets up this collision with prescale 0 and a reload value of 3. It then issues the status write in the third cycle after the reload write, which is the cycle computed for the zero event, and afterwards reads the status back. Prescaled timing gets the same treatment: the test reads the live count at a computed cycle and compares it to a known value. A behavioural model in the bench follows every channel on every clock, so interrupts and read data are compared on every cycle, not only at the directed points.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;

  localparam int DATA_W  = 32;
  localparam int PRE_W   = 8;
  localparam int PRE_LSB = 8;

  localparam int STS_WORD  = 6;
  localparam int WDOG_WORD = 7;
  localparam logic [DATA_W-1:0] WDOG_RST = 32'h0000_0400;

  typedef enum logic [1:0] {
    KIND_CTRL = 2'd0,
    KIND_INIT = 2'd1,
    KIND_CUR  = 2'd2
  } reg_kind_e;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             auto_rl;
    logic             ien;
    logic             run;
  } chan_ctrl_t;

  // word index of a channel register: pairs of channels share a 0x20 group
  function automatic int unsigned chan_word(int unsigned ch, reg_kind_e kind);
    return (ch / 2) * 8 + 32'(kind) * 2 + (ch % 2);
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_to_word(chan_ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[0] = c.run;
    w[1] = c.ien;
    w[2] = c.auto_rl;
    w[PRE_LSB +: PRE_W] = c.pre;
    return w;
  endfunction

  function automatic chan_ctrl_t word_to_ctrl(logic [DATA_W-1:0] w);
    chan_ctrl_t c;
    c.run     = w[0];
    c.ien     = w[1];
    c.auto_rl = w[2];
    c.pre     = w[PRE_LSB +: PRE_W];
    return c;
  endfunction

endpackage

// File: rtl/tmr_bank_decode.sv
module tmr_bank_decode
  import tmr_bank_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int ADDR_W = 12
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_CH-1:0] ctrl_we_o,
  output logic [NUM_CH-1:0] init_we_o,
  output logic [NUM_CH-1:0] ctrl_rd_o,
  output logic [NUM_CH-1:0] init_rd_o,
  output logic [NUM_CH-1:0] cur_rd_o,
  output logic              sts_we_o,
  output logic              sts_rd_o,
  output logic              wdog_rd_o
);

  localparam int WORD_W = ADDR_W - 2;

  logic              aligned;
  logic              wr_en;
  logic              rd_en;
  logic [WORD_W-1:0] word;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign word    = addr_i[ADDR_W-1:2];
  assign wr_en   = req_i & we_i & aligned;
  assign rd_en   = req_i & ~we_i & aligned;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int unsigned W_CTRL = chan_word(ch, KIND_CTRL);
    localparam int unsigned W_INIT = chan_word(ch, KIND_INIT);
    localparam int unsigned W_CUR  = chan_word(ch, KIND_CUR);

    logic hit_ctrl;
    logic hit_init;
    logic hit_cur;

    assign hit_ctrl = (word == WORD_W'(W_CTRL));
    assign hit_init = (word == WORD_W'(W_INIT));
    assign hit_cur  = (word == WORD_W'(W_CUR));

    assign ctrl_we_o[ch] = wr_en & hit_ctrl;
    assign init_we_o[ch] = wr_en & hit_init;
    assign ctrl_rd_o[ch] = rd_en & hit_ctrl;
    assign init_rd_o[ch] = rd_en & hit_init;
    assign cur_rd_o[ch]  = rd_en & hit_cur;
  end

  assign sts_we_o  = wr_en & (word == WORD_W'(STS_WORD));
  assign sts_rd_o  = rd_en & (word == WORD_W'(STS_WORD));
  assign wdog_rd_o = rd_en & (word == WORD_W'(WDOG_WORD));

endmodule

// File: rtl/tmr_bank_chan.sv
module tmr_bank_chan
  import tmr_bank_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              init_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output chan_ctrl_t        ctrl_o,
  output logic [CNT_W-1:0]  init_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              zero_o
);

  chan_ctrl_t       ctrl_q, ctrl_d;
  logic [CNT_W-1:0] init_q, init_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PRE_W-1:0] pcnt_q, pcnt_d;
  logic             active;
  logic             tick;
  logic             en;

  assign active = ctrl_q.run & (cnt_q != '0);
  assign tick   = (pcnt_q == ctrl_q.pre);
  assign en     = ctrl_we_i | init_we_i | active;

  always_comb begin
    ctrl_d = ctrl_q;
    init_d = init_q;
    cnt_d  = cnt_q;
    pcnt_d = pcnt_q;
    zero_o = 1'b0;
    if (ctrl_we_i) begin
      ctrl_d = word_to_ctrl(wdata_i);
      pcnt_d = '0;
    end else if (init_we_i) begin
      init_d = wdata_i[CNT_W-1:0];
      cnt_d  = wdata_i[CNT_W-1:0];
      pcnt_d = '0;
    end else if (active) begin
      if (tick) begin
        pcnt_d = '0;
        if (cnt_q == CNT_W'(1)) begin
          zero_o = 1'b1;
          if (ctrl_q.auto_rl) begin
            cnt_d = init_q;
          end else begin
            cnt_d      = '0;
            ctrl_d.run = 1'b0;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end else begin
        pcnt_d = pcnt_q + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      init_q <= '0;
      cnt_q  <= '0;
      pcnt_q <= '0;
    end else if (en) begin
      ctrl_q <= ctrl_d;
      init_q <= init_d;
      cnt_q  <= cnt_d;
      pcnt_q <= pcnt_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign init_o = init_q;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/tmr_bank_status.sv
module tmr_bank_status #(
  parameter int NUM_CH = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] set_i,
  input  logic              clr_we_i,
  input  logic [NUM_CH-1:0] clr_mask_i,
  input  logic [NUM_CH-1:0] irq_en_i,
  output logic [NUM_CH-1:0] sts_o,
  output logic [NUM_CH-1:0] irq_o
);

  logic [NUM_CH-1:0] sts_q, sts_d;
  logic [NUM_CH-1:0] clr;
  logic              en;

  assign clr = clr_we_i ? clr_mask_i : '0;
  assign en  = clr_we_i | (|set_i);

  always_comb begin
    // set after clear: a simultaneous event survives the clear
    sts_d = (sts_q & ~clr) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
    end else if (en) begin
      sts_q <= sts_d;
    end
  end

  assign sts_o = sts_q;
  assign irq_o = sts_q & irq_en_i;

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_bank_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] irq_o
);

  logic [NUM_CH-1:0] ctrl_we, init_we, ctrl_rd, init_rd, cur_rd;
  logic              sts_we, sts_rd, wdog_rd;
  logic [NUM_CH-1:0] zero_vec;
  logic [NUM_CH-1:0] ien_vec;
  logic [NUM_CH-1:0] sts_q;

  logic [DATA_W-1:0] ctrl_word [NUM_CH];
  logic [DATA_W-1:0] init_word [NUM_CH];
  logic [DATA_W-1:0] cnt_word  [NUM_CH];

  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rd_en;

  tmr_bank_decode #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
  ) u_decode (
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .ctrl_we_o (ctrl_we),
    .init_we_o (init_we),
    .ctrl_rd_o (ctrl_rd),
    .init_rd_o (init_rd),
    .cur_rd_o  (cur_rd),
    .sts_we_o  (sts_we),
    .sts_rd_o  (sts_rd),
    .wdog_rd_o (wdog_rd)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    chan_ctrl_t       ctrl;
    logic [CNT_W-1:0] init_val;
    logic [CNT_W-1:0] cnt_val;

    tmr_bank_chan #(
      .CNT_W (CNT_W)
    ) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctrl_we_i (ctrl_we[ch]),
      .init_we_i (init_we[ch]),
      .wdata_i   (wdata_i),
      .ctrl_o    (ctrl),
      .init_o    (init_val),
      .cnt_o     (cnt_val),
      .zero_o    (zero_vec[ch])
    );

    assign ien_vec[ch]   = ctrl.ien;
    assign ctrl_word[ch] = ctrl_to_word(ctrl);
    assign init_word[ch] = DATA_W'(init_val);
    assign cnt_word[ch]  = DATA_W'(cnt_val);
  end

  tmr_bank_status #(
    .NUM_CH (NUM_CH)
  ) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (zero_vec),
    .clr_we_i   (sts_we),
    .clr_mask_i (wdata_i[NUM_CH-1:0]),
    .irq_en_i   (ien_vec),
    .sts_o      (sts_q),
    .irq_o      (irq_o)
  );

  // read mux: at most one select is high, so an OR of gated words suffices
  always_comb begin
    rdata_d = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      rdata_d |= ctrl_rd[ch] ? ctrl_word[ch] : '0;
      rdata_d |= init_rd[ch] ? init_word[ch] : '0;
      rdata_d |= cur_rd[ch]  ? cnt_word[ch]  : '0;
    end
    rdata_d |= sts_rd  ? DATA_W'(sts_q) : '0;
    rdata_d |= wdog_rd ? WDOG_RST       : '0;
  end

  assign rd_en = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int NUM_CH = 5,
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic [NUM_CH-1:0] irq_o,
  input logic [NUM_CH-1:0] zero_vec,
  input logic [NUM_CH-1:0] sts_q,
  input logic [NUM_CH-1:0] ien_vec
);

  logic sts_wr;
  logic rd_req;

  assign sts_wr = req_i & we_i & (addr_i == ADDR_W'(32'h18));
  assign rd_req = req_i & ~we_i;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
    p_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      zero_vec[i] |=> sts_q[i]);

    p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_wr && wdata_i[i] && !zero_vec[i]) |=> !sts_q[i]);

    p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!zero_vec[i] && !(sts_wr && wdata_i[i])) |=> $stable(sts_q[i]));

    p_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ien_vec[i] |-> !irq_o[i]);

    p_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sts_q[i]) |-> !irq_o[i]);
  end

  p_unaligned_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && addr_i[1:0] != 2'b00) |=> (rdata_o == 32'h0));

  p_wdog_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && addr_i == ADDR_W'(32'h1C)) |=> (rdata_o == 32'h0000_0400));

  p_hold_rdata_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> $stable(rdata_o));

endmodule

bind tmr_bank tmr_bank_chk #(
  .NUM_CH (NUM_CH),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .zero_vec (zero_vec),
  .sts_q    (sts_q),
  .ien_vec  (ien_vec)
);

// File: tb/tmr_bank_bench.sv
`timescale 1ns/1ps
module tmr_bank_bench;

  logic        clk;
  logic        rst_n;
  logic        req;
  logic        we;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [4:0]  irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit cmp_on = 0;
  bit done   = 0;

  int ctrl_a [5] = '{'h00, 'h04, 'h20, 'h24, 'h40};
  int init_a [5] = '{'h08, 'h0C, 'h28, 'h2C, 'h48};
  int cur_a  [5] = '{'h10, 'h14, 'h30, 'h34, 'h50};

  // behavioural reference state
  bit [31:0] m_init [5];
  bit [31:0] m_cnt  [5];
  bit [7:0]  m_pre  [5];
  bit [7:0]  m_pcnt [5];
  bit        m_run  [5];
  bit        m_ien  [5];
  bit        m_auto [5];
  bit [4:0]  m_sts;
  bit [31:0] m_rd;

  tmr_bank u_tmr_bank (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .req_i   (req),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [31:0] mread(input bit [11:0] a);
    if (a == 12'h18) return {27'b0, m_sts};
    if (a == 12'h1C) return 32'h0000_0400;
    for (int i = 0; i < 5; i++) begin
      if (a == 12'(ctrl_a[i])) return {16'b0, m_pre[i], 5'b0, m_auto[i], m_ien[i], m_run[i]};
      if (a == 12'(init_a[i])) return m_init[i];
      if (a == 12'(cur_a[i]))  return m_cnt[i];
    end
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) begin
        m_init[i] = 0; m_cnt[i] = 0; m_pre[i] = 0; m_pcnt[i] = 0;
        m_run[i] = 0; m_ien[i] = 0; m_auto[i] = 0;
      end
      m_sts = 0;
      m_rd  = 0;
    end else begin
      bit [4:0] z;
      bit [4:0] clr;
      z = 0;
      if (req && !we) m_rd = mread(addr);
      for (int i = 0; i < 5; i++) begin
        if (req && we && addr == 12'(ctrl_a[i])) begin
          m_run[i] = wdata[0]; m_ien[i] = wdata[1]; m_auto[i] = wdata[2];
          m_pre[i] = wdata[15:8]; m_pcnt[i] = 0;
        end else if (req && we && addr == 12'(init_a[i])) begin
          m_init[i] = wdata; m_cnt[i] = wdata; m_pcnt[i] = 0;
        end else if (m_run[i] && m_cnt[i] != 0) begin
          if (m_pcnt[i] == m_pre[i]) begin
            m_pcnt[i] = 0;
            if (m_cnt[i] == 1) begin
              z[i] = 1;
              if (m_auto[i]) m_cnt[i] = m_init[i];
              else begin m_cnt[i] = 0; m_run[i] = 0; end
            end else m_cnt[i] = m_cnt[i] - 1;
          end else m_pcnt[i] = m_pcnt[i] + 1;
        end
      end
      clr = (req && we && addr == 12'h18) ? wdata[4:0] : 5'b0;
      m_sts = (m_sts & ~clr) | z;
    end
  end

  // per-clock comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      bit [4:0] ei;
      for (int i = 0; i < 5; i++) ei[i] = m_sts[i] & m_ien[i];
      check(irq === ei, "R5 irq vs model", 32'(irq), 32'(ei));
      check(rdata === m_rd, "R2 rdata vs model", rdata, m_rd);
    end
  end

  task automatic op(input bit r, input bit w, input int a, input logic [31:0] d);
    @(negedge clk);
    req = r; we = w; addr = 12'(a); wdata = d;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    op(1, 1, a, d);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) op(0, 0, 0, 0);
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
    op(1, 0, a, 0);
    op(0, 0, 0, 0);
    check(rdata === exp, tag, rdata, exp);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; req = 0; we = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n  = 1;
    cmp_on = 1;

    // R8: reset state
    check(irq === 5'b0, "R8 irq after reset", 32'(irq), 0);
    rd_chk('h18, 32'h0, "R8 status reset");
    rd_chk('h1C, 32'h400, "R8 watchdog reset");
    rd_chk('h00, 32'h0, "R8 ctrl0 reset");
    rd_chk('h50, 32'h0, "R8 count4 reset");

    // R1: every channel at its own offsets
    for (int i = 0; i < 5; i++) wr(init_a[i], 32'h100 + 32'(i) * 32'h11);
    for (int i = 0; i < 5; i++) begin
      rd_chk(cur_a[i],  32'h100 + 32'(i) * 32'h11, "R1 live count offset");
      rd_chk(init_a[i], 32'h100 + 32'(i) * 32'h11, "R1 reload offset");
      wr(ctrl_a[i], 32'hFFFF_0006 | (32'(i + 1) << 8));
      rd_chk(ctrl_a[i], 32'h0000_0006 | (32'(i + 1) << 8), "R9 ctrl fields R1");
      wr(ctrl_a[i], 32'h0);
    end

    // R2: read data holds across idle cycles
    rd_chk('h0C, 32'h111, "R2 read");
    idle(3);
    check(rdata === 32'h111, "R2 hold", rdata, 32'h111);

    // R6: live count is read-only
    wr('h14, 32'h55);
    rd_chk('h14, 32'h111, "R6 write to count ignored");

    // R7: unmapped and unaligned
    wr('h44, 32'hFFFF_FFFF);
    rd_chk('h44, 32'h0, "R7 unmapped read");
    rd_chk('h3C, 32'h0, "R7 unmapped read 3C");
    wr('h09, 32'h77);
    rd_chk('h0C, 32'h111, "R7 unaligned write ignored");
    rd_chk('h0D, 32'h0, "R7 unaligned read");

    // R8: watchdog word is constant
    wr('h1C, 32'h0);
    rd_chk('h1C, 32'h400, "R8 watchdog write ignored");

    // R9: prescaled one-shot on channel 2 (P=3, count 5)
    wr('h20, 32'h0000_0301);
    wr('h28, 32'h5);
    idle(4);
    rd_chk('h30, 32'h4, "R9 prescaled step");
    idle(30);
    rd_chk('h20, 32'h0000_0300, "R9 one-shot clears run");
    rd_chk('h30, 32'h0, "R9 one-shot stays zero");
    rd_chk('h18, 32'h4, "R3 status bit 2 set");
    check(irq[2] === 1'b0, "R5 gated by enable", 32'(irq), 0);

    // R5: enabling raises the line, clearing lowers it
    wr('h20, 32'h0000_0302);
    idle(1);
    check(irq[2] === 1'b1, "R5 enable raises irq", 32'(irq[2]), 1);
    wr('h18, 32'h4);
    idle(1);
    check(irq[2] === 1'b0, "R4 clear lowers irq", 32'(irq[2]), 0);
    rd_chk('h18, 32'h0, "R4 status cleared");

    // R4: zero event and clear on the same edge, channel 0
    wr('h00, 32'h1);
    wr('h08, 32'h3);
    idle(2);
    wr('h18, 32'h1);
    idle(1);
    rd_chk('h18, 32'h1, "R4 set wins over clear");

    // R4: zero bits leave status untouched
    wr('h04, 32'h1);
    wr('h0C, 32'h1);
    idle(3);
    rd_chk('h18, 32'h3, "R3 status bits 0 and 1");
    wr('h18, 32'h2);
    idle(1);
    rd_chk('h18, 32'h1, "R4 partial clear");

    // R9: auto-reload on channel 4
    wr('h40, 32'h7);
    wr('h48, 32'h2);
    idle(6);
    check(irq[4] === 1'b1, "R9 auto-reload raises irq", 32'(irq[4]), 1);
    rd_chk('h40, 32'h7, "R9 auto-reload keeps run");
    wr('h18, 32'h10);
    wr('h40, 32'h0);
    idle(4);

    done = 1;
    summary();
    $finish;
  end

endmodule